// File: doc/BRIEF.md
# Serial Register Port Slave

This block is a four-wire serial slave that gives an external host read and write access to an 8-bit register file of up to 128 entries. The host frames each transaction with an active-low select. It shifts bits on a serial clock into a data input. For reads it collects bits from a data output whose driver is enabled only while read data is being sent. The serial pins are resynchronised into the block clock domain. Every serial edge is then handled as a single-cycle event, so the serial clock must run well below the block clock: at least four block cycles per serial clock phase.

Every transaction opens with a device byte. Its upper seven bits must match the block's configured device number, and its lowest bit selects read (1) or write (0). A write then carries a pointer byte, which loads the register pointer and an increment flag, followed by any number of data bytes. A read streams out the register the pointer currently holds. The pointer and the flag keep their values after select rises, so a later read continues from where an earlier write left the pointer. The register file sits outside the block. It presents read data combinationally for the read address, and it takes writes through a one-cycle valid pulse that carries an address and data.

Top module: `regport_top`

## Requirements
- R1: After reset, `sdo_oe` and `reg_wr_valid` are low, and the pointer and increment flag are zero.
- R2: Input bits are sampled on rising `sck` edges while `cs_n` is low, most significant bit first.
- R3: In the first byte, bits 7..1 are the device number and bit 0 is the direction (1 = read). If bits 7..1 differ from `DEV_ADDR`, the rest of the transaction is ignored: no write pulse, and `sdo_oe` stays low until `cs_n` rises.
- R4: In a write, the second byte loads the pointer. Bit 7 is the increment flag and bits 6..0 are the register address.
- R5: Each complete data byte after the pointer byte gives exactly one single-cycle `reg_wr_valid` pulse, with `reg_wr_addr` set to the pointer and `reg_wr_data` set to the byte. There is no back-pressure: the register file must accept the write in that cycle.
- R6: In a read, the first falling `sck` edge after the device byte drives bit 7 of the register at the pointer onto `sdo`. Each later falling edge moves to the next lower bit.
- R7: `sdo_oe` is high only during a read addressed to this device. It rises on that first falling edge and drops within four block cycles after `cs_n` rises.
- R8: When the increment flag is set, the pointer advances by one after each complete data byte in either direction, and it wraps from 127 to 0.
- R9: When the increment flag is clear, repeated data bytes all use the same register.
- R10: Raising `cs_n` part-way through a byte discards that byte: no write pulse, and the pointer is unchanged.
- R11: A read uses the pointer left by an earlier transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| reg_rd_addr | output | 7 | Register file read address (pointer) |
| reg_rd_data | input | 8 | Register file read data, combinational |
| reg_wr_valid | output | 1 | Write strobe, one cycle per data byte |
| reg_wr_addr | output | 7 | Write address |
| reg_wr_data | output | 8 | Write data |

## Verification
The assertions assume that `cs_n` changes only while `sck` is low. They also assume that each serial clock phase lasts long enough for one edge to be seen and acted on before the next edge arrives. Under these conditions every synchronised edge becomes a single-cycle event, and every pointer step can be tied to a completed byte. The bench holds each `sck` level for eight block cycles and changes `sdi` and `cs_n` only while `sck` is low. It also leaves a gap of eight block cycles between select changes and the first or last edge.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVICE,
    ST_POINTER,
    ST_WRITE,
    ST_READ,
    ST_IGNORE
  } port_state_e;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= async_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_s,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  port_state_e        state;
  logic               sck_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-2:0]  in_sh;
  logic [BYTE_W-1:0]  out_sh;
  logic [AW-1:0]      ptr;
  logic               inc;
  logic               oe_q;

  logic               rise, fall, byte_done;
  logic [BYTE_W-1:0]  byte_in;

  assign rise      = sck_s & ~sck_q & ~cs_n_s;
  assign fall      = ~sck_s & sck_q & ~cs_n_s;
  assign byte_done = rise && (bit_cnt == CNT_W'(BYTE_W-1));
  assign byte_in   = {in_sh, sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sck_q    <= 1'b0;
      bit_cnt  <= '0;
      in_sh    <= '0;
      out_sh   <= '0;
      ptr      <= '0;
      inc      <= 1'b0;
      oe_q     <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      sck_q    <= sck_s;
      wr_valid <= 1'b0;
      if (cs_n_s) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else begin
        if (state == ST_IDLE) state <= ST_DEVICE;
        if (rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          in_sh   <= {in_sh[BYTE_W-3:0], sdi_s};
        end
        if (byte_done) begin
          unique case (state)
            ST_DEVICE: begin
              if (byte_in[7:1] != DEV_ADDR) state <= ST_IGNORE;
              else if (byte_in[0])         state <= ST_READ;
              else                         state <= ST_POINTER;
            end
            ST_POINTER: begin
              ptr   <= byte_in[AW-1:0];
              inc   <= byte_in[7];
              state <= ST_WRITE;
            end
            ST_WRITE: begin
              wr_valid <= 1'b1;
              wr_addr  <= ptr;
              wr_data  <= byte_in;
              if (inc) ptr <= ptr + 1'b1;
            end
            ST_READ: begin
              if (inc) ptr <= ptr + 1'b1;
            end
            default: ;
          endcase
        end
        if (fall && state == ST_READ) begin
          if (bit_cnt == '0) begin
            out_sh <= rd_data;
            oe_q   <= 1'b1;
          end else begin
            out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_addr = ptr;
  assign sdo     = out_sh[BYTE_W-1];
  assign sdo_oe  = oe_q;

  // R7
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !sdo_oe);
  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> (!sdo_oe && !wr_valid));
  // R5
  write_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(state) == ST_WRITE && $past(byte_done)));
  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && inc && (state == ST_READ || state == ST_WRITE))
      |=> (ptr == AW'($past(ptr) + 1'b1)));
  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !inc && (state == ST_READ || state == ST_WRITE)) |=> $stable(ptr));
  // R10
  ptr_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(ptr));
endmodule

// File: rtl/regport_top.sv
module regport_top #(
  parameter int unsigned AW = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] reg_rd_addr,
  input  logic [7:0]    reg_rd_data,
  output logic          reg_wr_valid,
  output logic [AW-1:0] reg_wr_addr,
  output logic [7:0]    reg_wr_data
);
  localparam int unsigned PIN_N = 3;
  logic [PIN_N-1:0] pins_s;

  regport_sync #(.WIDTH(PIN_N), .STAGES(2), .RST_VAL(3'b100)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({cs_n, sck, sdi}),
    .sync_o (pins_s)
  );

  regport_ctrl #(.AW(AW), .DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (pins_s[2]),
    .sck_s   (pins_s[1]),
    .sdi_s   (pins_s[0]),
    .rd_data (reg_rd_data),
    .rd_addr (reg_rd_addr),
    .wr_valid(reg_wr_valid),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );
endmodule

// File: tb/regport_top_tb.sv
module regport_top_tb_top;
  localparam int unsigned AW = 7;
  localparam logic [7:0] DEV_W = 8'h24;
  localparam logic [7:0] DEV_R = 8'h25;
  localparam int unsigned HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, reg_wr_valid;
  logic [AW-1:0] reg_rd_addr, reg_wr_addr;
  logic [7:0] reg_rd_data, reg_wr_data;
  logic [7:0] regmem [128];
  int checks = 0, errors = 0, wr_count = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  regport_top dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .reg_wr_valid(reg_wr_valid),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regmem[i] <= 8'h00;
      wr_count <= 0;
    end else if (reg_wr_valid) begin
      regmem[reg_wr_addr] <= reg_wr_data;
      wr_count <= wr_count + 1;
    end
  end
  assign reg_rd_data = regmem[reg_rd_addr];

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_tx();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_tx();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int b = 0; b < n; b++) begin
      sdi = tx[7-b];
      wait_clk(HALF);
      rx[7-b] = sdo;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    send_bits(tx, 8, rx);
  endtask

  // {pointer byte (bit7 = increment flag), data}
  localparam logic [15:0] VEC [6] = '{
    {8'h05, 8'hA5}, {8'h00, 8'h3C}, {8'h7F, 8'hFF},
    {8'h40, 8'h01}, {8'h2A, 8'h80}, {8'h63, 8'h5E}};

  initial begin
    logic [7:0] rx;
    int wc;
    wait_clk(5);
    // R1 reset state
    check("R1 oe", sdo_oe, 0);
    check("R1 wr_valid", reg_wr_valid, 0);
    check("R1 pointer", reg_rd_addr, 0);
    rst_n = 1'b1;
    wait_clk(4);

    for (int v = 0; v < 6; v++) begin
      wc = wr_count;
      begin_tx(); xfer(DEV_W, rx); xfer(VEC[v][15:8], rx);
      check("R7 oe low in write", sdo_oe, 0);
      xfer(VEC[v][7:0], rx); end_tx();
      check("R5 one pulse", wr_count, wc + 1);
      check("R2 R4 R5 stored", regmem[VEC[v][14:8]], VEC[v][7:0]);
      begin_tx(); xfer(DEV_R, rx);
      check("R7 oe low before first fall", sdo_oe, 0);
      xfer(8'h00, rx);
      check("R7 oe high in read", sdo_oe, 1);
      check("R6 R11 read back", rx, VEC[v][7:0]);
      end_tx();
      check("R7 oe dropped", sdo_oe, 0);
    end

    // R8 burst write with wrap 7E,7F,00
    wc = wr_count;
    begin_tx(); xfer(DEV_W, rx); xfer(8'hFE, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx); end_tx();
    check("R5 burst pulses", wr_count, wc + 3);
    check("R8 7E", regmem[7'h7E], 8'h11);
    check("R8 7F", regmem[7'h7F], 8'h22);
    check("R8 wrap 00", regmem[7'h00], 8'h33);
    // R11 pointer-only write, then burst read with wrap
    begin_tx(); xfer(DEV_W, rx); xfer(8'hFE, rx); end_tx();
    begin_tx(); xfer(DEV_R, rx);
    xfer(8'h00, rx); check("R8 R11 read 7E", rx, 8'h11);
    xfer(8'h00, rx); check("R8 read 7F", rx, 8'h22);
    xfer(8'h00, rx); check("R8 read wrap 00", rx, 8'h33);
    end_tx();

    // R9 no increment: same register reused
    begin_tx(); xfer(DEV_W, rx); xfer(8'h10, rx);
    xfer(8'hAA, rx); xfer(8'hBB, rx); end_tx();
    check("R9 last write wins", regmem[7'h10], 8'hBB);
    check("R9 neighbour untouched", regmem[7'h11], 8'h00);
    begin_tx(); xfer(DEV_R, rx);
    xfer(8'h00, rx); check("R9 read 1", rx, 8'hBB);
    xfer(8'h00, rx); check("R9 read 2", rx, 8'hBB);
    end_tx();

    // R3 wrong device number
    wc = wr_count;
    begin_tx(); xfer(8'h44, rx); xfer(8'h20, rx); xfer(8'h5A, rx); end_tx();
    check("R3 no write", wr_count, wc);
    check("R3 reg untouched", regmem[7'h20], 8'h00);
    begin_tx(); xfer(8'h45, rx); xfer(8'h00, rx);
    check("R3 oe stays low", sdo_oe, 0);
    end_tx();

    // R10 abort mid data byte and mid pointer byte
    begin_tx(); xfer(DEV_W, rx); xfer(8'h30, rx); xfer(8'h3C, rx); end_tx();
    wc = wr_count;
    begin_tx(); xfer(DEV_W, rx); xfer(8'h30, rx); send_bits(8'hC3, 4, rx); end_tx();
    check("R10 no write on partial", wr_count, wc);
    check("R10 reg kept", regmem[7'h30], 8'h3C);
    begin_tx(); xfer(DEV_W, rx); send_bits(8'h55, 5, rx); end_tx();
    begin_tx(); xfer(DEV_R, rx); xfer(8'h00, rx); end_tx();
    check("R10 R11 pointer kept", rx, 8'h3C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule